// File: doc/BRIEF.md
# Dual ADC Output Format Controller

This block sits between two converter channels and their parallel output pins. On each sample clock it accepts a pair of offset-binary codes, one per channel, qualified by a shared valid flag. It carries them through a fixed pipeline and presents both channels on their output buses in the same clock edge. A runtime select line chooses between offset-binary and two's-complement coding. Two's complement is formed by flipping the most significant bit.

Three control lines manage the buses at runtime. A sleep request and a power-down request both stop new samples from entering the pipeline and freeze the output registers at their last value. Once the request is released, the outputs keep holding for a parameterised wake-up count of clock cycles before fresh codes are accepted. An output-disable line drives the per-bus drive-enable outputs directly, without passing through the clock, so the pad tri-state control works even with no clock running.

Top module: `dual_adc_fmt_ctrl`

## Requirements
- R1: With `fmt_twos` low, each bus shows its channel's input code unchanged (offset binary: 0x000 is negative full scale, 0x3FF is positive full scale).
- R2: With `fmt_twos` high, each bus shows its input code with only bit DATA_W-1 inverted. For example, 0x3FF gives 0x1FF, 0x200 gives 0x000, 0x000 gives 0x200 and 0x001 gives 0x201.
- R3: `fmt_twos` is registered. The value captured at one rising edge governs codes loaded at later edges, and a change of the select never alters a value already held on the buses.
- R4: A code pair captured with `code_vld` high at rising edge k appears on both buses together right after edge k+LATENCY-1 (LATENCY edges counting the capture edge), and not before.
- R5: `drv_en_a` and `drv_en_b` are the inverse of `out_dis` at all times, with no dependence on the clock or on reset.
- R6: While `pdn_req` is high, both buses keep the last value loaded before power-down, and codes offered meanwhile are never loaded.
- R7: While `sleep_req` is high, no new samples enter the pipeline and both buses keep their value.
- R8: After sleep and power-down are both released, the buses hold for WAKE_CYC rising edges. The first new code may load at the edge after that.
- R9: During reset both buses read 0x000.
- R10: A code offered with `code_vld` low is never loaded onto the buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_a_code | input | DATA_W | Channel A offset-binary code |
| ch_b_code | input | DATA_W | Channel B offset-binary code |
| code_vld | input | 1 | Both channel codes are valid this cycle |
| fmt_twos | input | 1 | 0: offset binary, 1: two's complement |
| sleep_req | input | 1 | Sleep: stop sampling, hold outputs |
| pdn_req | input | 1 | Power-down: stop sampling, hold outputs |
| out_dis | input | 1 | 1: buses released to high impedance |
| bus_a | output | DATA_W | Channel A output data |
| bus_b | output | DATA_W | Channel B output data |
| drv_en_a | output | 1 | Drive enable for bus A pads |
| drv_en_b | output | 1 | Drive enable for bus B pads |

## Verification
The bench samples both buses one edge before and exactly at the end of the pipeline delay. A design off by one stage would show the new code early or late there. It changes the format select while the buses are frozen, so a design that recodes held data on the fly would show a flipped top bit. It releases sleep and power-down with fresh codes already waiting. A design that skipped the wake-up count would load them up to WAKE_CYC edges too early, and one that counted one edge too many would still show stale data at the expected edge. It also toggles the output-disable line with the clock idle, which exposes a drive enable that was registered.

// File: rtl/dafc_pkg.sv
package dafc_pkg;
   typedef enum logic {
      FMT_OFFSET = 1'b0,
      FMT_TWOS   = 1'b1
   } fmt_e;

   localparam int unsigned MIN_DATA_W = 2;

   function automatic int unsigned cnt_bits(input int unsigned max_val);
      return (max_val < 1) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/dafc_delay_line.sv
module dafc_delay_line #(
   parameter int unsigned DATA_W = 10,
   parameter int unsigned DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_a,
   output logic [DATA_W-1:0] out_b
);
   generate
      if (DEPTH == 0) begin : g_pass
         assign out_vld = in_vld;
         assign out_a   = in_a;
         assign out_b   = in_b;
      end else begin : g_pipe
         logic              vld_q [DEPTH];
         logic [DATA_W-1:0] a_q   [DEPTH];
         logic [DATA_W-1:0] b_q   [DEPTH];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) begin
                  vld_q[i] <= 1'b0;
                  a_q[i]   <= '0;
                  b_q[i]   <= '0;
               end
            end else begin
               vld_q[0] <= in_vld;
               a_q[0]   <= in_a;
               b_q[0]   <= in_b;
               for (int i = 1; i < DEPTH; i++) begin
                  vld_q[i] <= vld_q[i-1];
                  a_q[i]   <= a_q[i-1];
                  b_q[i]   <= b_q[i-1];
               end
            end
         end

         assign out_vld = vld_q[DEPTH-1];
         assign out_a   = a_q[DEPTH-1];
         assign out_b   = b_q[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/dafc_wake_timer.sv
module dafc_wake_timer #(
   parameter int unsigned WAKE_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic idle_req,
   output logic busy
);
   import dafc_pkg::*;

   localparam int unsigned CNT_W = cnt_bits(WAKE_CYC);

   generate
      if (WAKE_CYC == 0) begin : g_none
         assign busy = 1'b0;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (idle_req) begin
               cnt_q <= CNT_W'(WAKE_CYC);
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign busy = (cnt_q != '0);
      end
   endgenerate
endmodule

// File: rtl/dafc_out_stage.sv
module dafc_out_stage #(
   parameter int unsigned DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fmt_sel,
   input  logic              load,
   input  logic [DATA_W-1:0] code_a,
   input  logic [DATA_W-1:0] code_b,
   output logic [DATA_W-1:0] bus_a,
   output logic [DATA_W-1:0] bus_b
);
   import dafc_pkg::*;

   localparam int unsigned MSB = DATA_W - 1;

   fmt_e              fmt_q;
   logic [DATA_W-1:0] flip_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fmt_q <= FMT_OFFSET;
      else        fmt_q <= fmt_e'(fmt_sel);
   end

   always_comb begin
      flip_mask      = '0;
      flip_mask[MSB] = (fmt_q == FMT_TWOS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_a <= '0;
         bus_b <= '0;
      end else if (load) begin
         bus_a <= code_a ^ flip_mask;
         bus_b <= code_b ^ flip_mask;
      end
   end
endmodule

// File: rtl/dual_adc_fmt_ctrl.sv
module dual_adc_fmt_ctrl #(
   parameter int unsigned DATA_W   = 10,
   parameter int unsigned LATENCY  = 5,
   parameter int unsigned WAKE_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ch_a_code,
   input  logic [DATA_W-1:0] ch_b_code,
   input  logic              code_vld,
   input  logic              fmt_twos,
   input  logic              sleep_req,
   input  logic              pdn_req,
   input  logic              out_dis,
   output logic [DATA_W-1:0] bus_a,
   output logic [DATA_W-1:0] bus_b,
   output logic              drv_en_a,
   output logic              drv_en_b
);
   import dafc_pkg::*;

   localparam int unsigned PIPE_DEPTH = LATENCY - 1;

   generate
      if (DATA_W < MIN_DATA_W) begin : g_bad_width
         $error("dual_adc_fmt_ctrl: DATA_W must be at least 2");
      end
      if (LATENCY < 1) begin : g_bad_latency
         $error("dual_adc_fmt_ctrl: LATENCY must be at least 1");
      end
   endgenerate

   logic              idle_req;
   logic              wake_busy;
   logic              pipe_vld;
   logic [DATA_W-1:0] pipe_a;
   logic [DATA_W-1:0] pipe_b;
   logic              load_out;

   assign idle_req = sleep_req | pdn_req;

   dafc_delay_line #(
      .DATA_W (DATA_W),
      .DEPTH  (PIPE_DEPTH)
   ) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (code_vld & ~idle_req),
      .in_a    (ch_a_code),
      .in_b    (ch_b_code),
      .out_vld (pipe_vld),
      .out_a   (pipe_a),
      .out_b   (pipe_b)
   );

   dafc_wake_timer #(
      .WAKE_CYC (WAKE_CYC)
   ) u_wake (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle_req (idle_req),
      .busy     (wake_busy)
   );

   assign load_out = pipe_vld & ~idle_req & ~wake_busy;

   dafc_out_stage #(
      .DATA_W (DATA_W)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .fmt_sel (fmt_twos),
      .load    (load_out),
      .code_a  (pipe_a),
      .code_b  (pipe_b),
      .bus_a   (bus_a),
      .bus_b   (bus_b)
   );

   assign drv_en_a = ~out_dis;
   assign drv_en_b = ~out_dis;
endmodule

// File: rtl/dafc_checker.sv
module dafc_checker #(
   parameter int unsigned DATA_W   = 10,
   parameter int unsigned WAKE_CYC = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sleep_req,
   input logic              pdn_req,
   input logic              out_dis,
   input logic              wake_busy,
   input logic [DATA_W-1:0] bus_a,
   input logic [DATA_W-1:0] bus_b,
   input logic              drv_en_a,
   input logic              drv_en_b
);
   // R5: pads released whenever outputs are disabled
   p_drive_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_dis |-> (!drv_en_a && !drv_en_b));

   // R5: pads driven whenever outputs are enabled
   p_drive_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !out_dis |-> (drv_en_a && drv_en_b));

   // R6: no bus update at an edge where power-down was sampled high
   p_pdn_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pdn_req) |-> ($stable(bus_a) && $stable(bus_b)));

   // R7: no bus update at an edge where sleep was sampled high
   p_sleep_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sleep_req) |-> ($stable(bus_a) && $stable(bus_b)));

   // R8: buses frozen while the wake-up count runs
   p_wake_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wake_busy) |-> ($stable(bus_a) && $stable(bus_b)));

   generate
      if (WAKE_CYC > 0) begin : g_arm
         // R8: every idle request arms the wake-up count
         p_wake_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (sleep_req || pdn_req) |=> wake_busy);
      end
   endgenerate
endmodule

bind dual_adc_fmt_ctrl dafc_checker #(
   .DATA_W   (DATA_W),
   .WAKE_CYC (WAKE_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sleep_req (sleep_req),
   .pdn_req   (pdn_req),
   .out_dis   (out_dis),
   .wake_busy (wake_busy),
   .bus_a     (bus_a),
   .bus_b     (bus_b),
   .drv_en_a  (drv_en_a),
   .drv_en_b  (drv_en_b)
);

// File: tb/tb_dual_adc_fmt_ctrl.sv
`timescale 1ns/1ps
module tb_dual_adc_fmt_ctrl;
   localparam int unsigned DW   = 10;
   localparam int unsigned LAT  = 5;
   localparam int unsigned WAKE = 8;

   typedef struct packed {
      logic [DW-1:0] a;
      logic [DW-1:0] b;
      logic          f;
      logic [DW-1:0] ea;
      logic [DW-1:0] eb;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{a:10'h000, b:10'h3FF, f:1'b0, ea:10'h000, eb:10'h3FF},
      '{a:10'h200, b:10'h1FF, f:1'b0, ea:10'h200, eb:10'h1FF},
      '{a:10'h201, b:10'h001, f:1'b0, ea:10'h201, eb:10'h001},
      '{a:10'h3FF, b:10'h000, f:1'b1, ea:10'h1FF, eb:10'h200},
      '{a:10'h200, b:10'h201, f:1'b1, ea:10'h000, eb:10'h001},
      '{a:10'h1FF, b:10'h001, f:1'b1, ea:10'h3FF, eb:10'h201},
      '{a:10'h155, b:10'h2AA, f:1'b1, ea:10'h355, eb:10'h0AA},
      '{a:10'h0F0, b:10'h30F, f:1'b0, ea:10'h0F0, eb:10'h30F}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] ch_a_code = '0;
   logic [DW-1:0] ch_b_code = '0;
   logic          code_vld = 1'b0;
   logic          fmt_twos = 1'b0;
   logic          sleep_req = 1'b0;
   logic          pdn_req = 1'b0;
   logic          out_dis = 1'b0;
   logic [DW-1:0] bus_a, bus_b;
   logic          drv_en_a, drv_en_b;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dual_adc_fmt_ctrl #(.DATA_W(DW), .LATENCY(LAT), .WAKE_CYC(WAKE)) dut (
      .clk(clk), .rst_n(rst_n), .ch_a_code(ch_a_code), .ch_b_code(ch_b_code),
      .code_vld(code_vld), .fmt_twos(fmt_twos), .sleep_req(sleep_req),
      .pdn_req(pdn_req), .out_dis(out_dis), .bus_a(bus_a), .bus_b(bus_b),
      .drv_en_a(drv_en_a), .drv_en_b(drv_en_b)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
      end
   endtask

   task automatic chk_pair(input string req, input logic [DW-1:0] ea, input logic [DW-1:0] eb);
      chk({req, " bus_a"}, bus_a, ea);
      chk({req, " bus_b"}, bus_b, eb);
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic v);
      ch_a_code = a;
      ch_b_code = b;
      code_vld  = v;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R9: reset state; R5: drive enable tracks out_dis even in reset with no edge
      step(3);
      chk_pair("R9 reset", 10'h000, 10'h000);
      out_dis = 1'b1;
      #0.5;
      chk("R5 disable in reset", {9'd0, drv_en_a | drv_en_b}, 10'd0);
      out_dis = 1'b0;
      #0.5;
      chk("R5 enable in reset", {9'd0, drv_en_a & drv_en_b}, 10'd1);
      @(negedge clk);
      rst_n = 1'b1;
      step(1);

      // R1 / R2: vector walk
      for (int i = 0; i < NVEC; i++) begin
         drive(VECS[i].a, VECS[i].b, 1'b1);
         fmt_twos = VECS[i].f;
         step(LAT + 2);
         chk_pair(VECS[i].f ? "R2 twos vector" : "R1 offset vector", VECS[i].ea, VECS[i].eb);
      end

      // R4: single-cycle sample, latency edge exact; R10: invalid codes ignored
      drive(10'h123, 10'h321, 1'b1);
      step(1);
      drive(10'h3AB, 10'h0BA, 1'b0);
      step(LAT - 2);
      chk_pair("R4 before latency", 10'h0F0, 10'h30F);
      step(1);
      chk_pair("R4 at latency", 10'h123, 10'h321);
      step(LAT + 3);
      chk_pair("R10 invalid ignored", 10'h123, 10'h321);

      // R5: async drive enable with clock running, checked mid-cycle
      #0.5 out_dis = 1'b1;
      #0.5 chk("R5 disable", {9'd0, drv_en_a | drv_en_b}, 10'd0);
      out_dis = 1'b0;
      #0.5 chk("R5 enable", {9'd0, drv_en_a & drv_en_b}, 10'd1);
      @(negedge clk);

      // R6: power-down hold; R3: format change does not touch held data
      pdn_req = 1'b1;
      drive(10'h0AA, 10'h055, 1'b1);
      step(10);
      chk_pair("R6 pdn hold", 10'h123, 10'h321);
      fmt_twos = 1'b1;
      step(3);
      chk_pair("R3 fmt on held data", 10'h123, 10'h321);
      // R8: wake-up count after power-down release
      pdn_req = 1'b0;
      step(WAKE);
      chk_pair("R8 pdn wake hold", 10'h123, 10'h321);
      step(1);
      chk_pair("R8 pdn wake load", 10'h2AA, 10'h255);

      // R7: sleep hold, then R8 wake-up
      sleep_req = 1'b1;
      drive(10'h3C3, 10'h03C, 1'b1);
      step(10);
      chk_pair("R7 sleep hold", 10'h2AA, 10'h255);
      sleep_req = 1'b0;
      step(WAKE);
      chk_pair("R8 sleep wake hold", 10'h2AA, 10'h255);
      step(1);
      chk_pair("R8 sleep wake load", 10'h1C3, 10'h23C);

      // R3: format switch back applies to later samples
      fmt_twos = 1'b0;
      step(LAT + 2);
      chk_pair("R3 fmt switch back", 10'h3C3, 10'h03C);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule